// File: doc/BRIEF.md
# Transmit Flow Gate with Automatic Clear-To-Send

This block sits between a UART's transmit holding FIFO and its serial shifter. It decides in which clock cycle the shifter may take the next character. The shifter reports that it is busy while a frame is on the line. The FIFO reports that it holds at least one character. The gate issues a one-cycle start strobe only when a character is waiting, the shifter is idle and nothing is holding transmission back.

Two things can hold transmission back. The first is a software transmitter-disable bit. The second, when automatic flow control is switched on, is the active-low clear-to-send input from the remote end. That input is asynchronous, so it passes through a flop synchronizer before it is used. The gate acts only between characters: a frame that has already started always finishes, and a blocked character waits until the hold is lifted. A stall flag shows that a character is ready to go but is being held back.

Top module: `auto_cts_tx_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `start_next` and `tx_stalled` are 0 after that edge. The clear-to-send synchronizer resets to the "not clear" level (1).
- R2: Define `hold = tx_disable | (auto_cts_en & cts_sync)`, where `cts_sync` is `cts_n_in` delayed by two flops. `start_next` is 1 after an edge exactly when, at that edge, `fifo_nonempty` was 1, `shifter_busy` was 0, `hold` was 0 and `start_next` was 0.
- R3: `start_next` is never 1 in two consecutive cycles.
- R4: No start is issued in the cycle after `shifter_busy` was 1, so a frame in progress is never interrupted.
- R5: With `tx_disable` = 1, no start is issued, whatever the clear-to-send level.
- R6: With `auto_cts_en` = 0, `cts_n_in` has no effect on `start_next` or `tx_stalled`.
- R7: With `auto_cts_en` = 1 and the synchronized `cts_n_in` at 1, no start is issued.
- R8: When `cts_n_in` falls to 0 while a character waits, `start_next` is still 0 after the second following edge and rises at the third.
- R9: `tx_stalled` is 1 after an edge exactly when, at that edge, `fifo_nonempty` was 1, `shifter_busy` was 0 and `hold` was 1.
- R10: `start_next` and `tx_stalled` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_n_in | input | 1 | Asynchronous clear-to-send, active low |
| auto_cts_en | input | 1 | Enables automatic flow control from `cts_n_in` |
| tx_disable | input | 1 | Software transmitter disable |
| fifo_nonempty | input | 1 | Holding FIFO has at least one character |
| shifter_busy | input | 1 | Shifter is sending a frame |
| start_next | output | 1 | One-cycle strobe: shifter takes the next character |
| tx_stalled | output | 1 | A character is ready but held by disable or clear-to-send |

## Verification
The hardest case to reach from the ports is a change of clear-to-send that lands exactly while a character waits and the shifter is idle. Only there does the two-flop latency decide whether a strobe leaks out one cycle early. A directed phase parks the gate in a CTS stall and then drops `cts_n_in`. It checks the edge before the strobe and the edge on which the strobe appears. A long random run then toggles all inputs with biased weights so that stalls, resumes and busy windows overlap at random offsets.

// File: rtl/tfg_pkg.sv
// Package: shared parameters and types for the transmit flow gate.
// Assumes: single clock domain apart from the clear-to-send input.
package tfg_pkg;
    localparam int unsigned CTS_SYNC_STAGES = 2;

    // Decision of the gate for the current cycle
    typedef struct packed {
        logic ready;   // a start may be issued
        logic held;    // a character waits but is held back
    } gate_dec_t;
endpackage

// File: rtl/tfg_sync.sv
// Module: tfg_sync
// Brings an asynchronous level into the clock domain through a flop chain.
// Assumes: STAGES >= 2. Reset is synchronous, and the chain presets to RST_VAL.
module tfg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // shift the input level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tfg_decide.sv
// Module: tfg_decide
// Combines the hold sources with the FIFO and shifter state into one decision.
// Assumes: cts_sync is already synchronized and active high means "not clear".
module tfg_decide
    import tfg_pkg::*;
(
    input  logic      cts_sync,
    input  logic      auto_cts_en,
    input  logic      tx_disable,
    input  logic      fifo_nonempty,
    input  logic      shifter_busy,
    input  logic      start_q,
    output gate_dec_t dec
);
    logic hold;
    logic at_boundary;

    // evaluate the hold sources and the character boundary
    always_comb begin
        hold        = tx_disable | (auto_cts_en & cts_sync);
        at_boundary = fifo_nonempty & ~shifter_busy;
        dec.ready   = at_boundary & ~hold & ~start_q;
        dec.held    = at_boundary & hold;
    end
endmodule

// File: rtl/tfg_strobe.sv
// Module: tfg_strobe
// Registers the gate decision into the start strobe and the stall flag.
// Assumes: the shifter raises busy in the cycle after it sees the strobe.
module tfg_strobe
    import tfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  gate_dec_t dec,
    input  logic      shifter_busy,
    input  logic      tx_disable,
    output logic      start_q,
    output logic      stalled_q
);
    // register the strobe and the stall flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            stalled_q <= 1'b0;
        end else begin
            start_q   <= dec.ready;
            stalled_q <= dec.held;
        end
    end

    // R3: the strobe lasts one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R4: no start right after busy
    a_r4_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_busy |=> !start_q);
    // R5: a disable blocks the start
    a_r5_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        tx_disable |=> !start_q);
    // R10: strobe and stall are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && stalled_q));
endmodule

// File: rtl/auto_cts_tx_gate.sv
// Module: auto_cts_tx_gate (top)
// Issues a start strobe to the transmit shifter only at character boundaries.
// Holds it while software disables the transmitter or, if automatic flow
// control is on, while the synchronized clear-to-send is deasserted.
// Assumes: synchronous active-low reset; cts_n_in may be asynchronous.
module auto_cts_tx_gate
    import tfg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = CTS_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_in,
    input  logic auto_cts_en,
    input  logic tx_disable,
    input  logic fifo_nonempty,
    input  logic shifter_busy,
    output logic start_next,
    output logic tx_stalled
);
    logic      cts_sync;
    gate_dec_t dec;
    logic      start_q;
    logic      stalled_q;

    tfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cts_n_in),
        .q_sync  (cts_sync)
    );

    tfg_decide u_decide (
        .cts_sync      (cts_sync),
        .auto_cts_en   (auto_cts_en),
        .tx_disable    (tx_disable),
        .fifo_nonempty (fifo_nonempty),
        .shifter_busy  (shifter_busy),
        .start_q       (start_q),
        .dec           (dec)
    );

    tfg_strobe u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec          (dec),
        .shifter_busy (shifter_busy),
        .tx_disable   (tx_disable),
        .start_q      (start_q),
        .stalled_q    (stalled_q)
    );

    assign start_next = start_q;
    assign tx_stalled = stalled_q;

    // R7: synchronized CTS high with auto mode on blocks the start
    a_r7_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && cts_sync) |=> !start_next);
    // R9: an empty FIFO never reports a stall
    a_r9_no_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |=> !tx_stalled);
endmodule

// File: tb/auto_cts_tx_gate_tb.sv
module auto_cts_tx_gate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n_in = 1'b1, auto_cts_en = 1'b0, tx_disable = 1'b0;
    logic fifo_nonempty = 1'b0, shifter_busy = 1'b0;
    logic start_next, tx_stalled;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4ns clk = ~clk;   // 125 MHz

    auto_cts_tx_gate u_dut (
        .clk(clk), .rst_n(rst_n), .cts_n_in(cts_n_in),
        .auto_cts_en(auto_cts_en), .tx_disable(tx_disable),
        .fifo_nonempty(fifo_nonempty), .shifter_busy(shifter_busy),
        .start_next(start_next), .tx_stalled(tx_stalled)
    );

    // reference built from R1, R2 and R9
    logic m_s1 = 1'b1, m_s2 = 1'b1, m_start = 1'b0, m_stall = 1'b0;

    function automatic logic f_hold(logic dis, logic aut, logic cs);
        return dis | (aut & cs);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_start <= 1'b0; m_stall <= 1'b0;
        end else begin
            m_s1    <= cts_n_in;
            m_s2    <= m_s1;
            m_start <= fifo_nonempty & ~shifter_busy
                       & ~f_hold(tx_disable, auto_cts_en, m_s2) & ~m_start;
            m_stall <= fifo_nonempty & ~shifter_busy
                       & f_hold(tx_disable, auto_cts_en, m_s2);
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // advance one cycle and compare against the reference away from the edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R2 start", start_next, m_start);
        check("R9 stall", tx_stalled, m_stall);
        check("R10 exclusive", start_next & tx_stalled, 1'b0);
    endtask

    initial begin
        #(8ns * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        // R1: reset state
        fifo_nonempty = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 start", start_next, 1'b0);
        check("R1 stall", tx_stalled, 1'b0);
        rst_n = 1'b1;

        // R6: auto off, CTS# high is ignored
        auto_cts_en = 1'b0; cts_n_in = 1'b1;
        step(); check("R6 start with cts high", start_next, 1'b1);
        step(); check("R3 no second strobe", start_next, 1'b0);
        step(); check("R6 start again", start_next, 1'b1);

        // R5: disable blocks, stall reported
        tx_disable = 1'b1;
        step(); step();
        check("R5 start", start_next, 1'b0);
        check("R5 stall", tx_stalled, 1'b1);

        // R7: auto on with CTS# high
        tx_disable = 1'b0; auto_cts_en = 1'b1;
        step(); step(); step();
        check("R7 start", start_next, 1'b0);
        check("R7 stall", tx_stalled, 1'b1);

        // R8: CTS# low reaches the strobe on the third edge
        cts_n_in = 1'b0;
        step(); step();
        check("R8 still held", start_next, 1'b0);
        step();
        check("R8 resumed", start_next, 1'b1);

        // R4: busy shifter gets no start
        shifter_busy = 1'b1;
        step(); step();
        check("R4 start", start_next, 1'b0);
        check("R4 stall", tx_stalled, 1'b0);
        shifter_busy = 1'b0;

        // random phase: biased stimulus
        for (int i = 0; i < 4000; i++) begin
            cts_n_in      = ($urandom % 4) == 0;
            auto_cts_en   = ($urandom % 3) != 0;
            tx_disable    = ($urandom % 6) == 0;
            fifo_nonempty = ($urandom % 4) != 0;
            shifter_busy  = ($urandom % 3) == 0;
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule